// File: doc/BRIEF.md
# Two-Lane Serial I/Q Transmitter

This block accepts one parallel I/Q sample at a time through a valid/ready handshake and shifts it out as two single-bit serial streams, one carrying the I word and one carrying the Q word, both in step with each other. Each clock cycle of the system clock is one bit period. A bit-enable output marks the cycles that carry sample bits. A one-cycle strobe marks the first bit of every sample.

The sample width can be 16 or 12 bits, and the bit order can be most-significant first (the default) or least-significant first. Both settings are captured only when a new sample is taken, so a change made while a sample is being sent applies from the next sample onward. The block raises ready during the last bit of a sample. When a word is waiting, its first bit therefore follows the previous last bit with no idle cycle between them. With no word pending, both lanes and the strobe stay low.

Top module: `iq_serial_tx`

## Requirements
- R1: While rst_n is low, in_ready is 1 and bit_en, strobe, ser_i and ser_q are all 0.
- R2: A word accepted at a clock edge (in_valid and in_ready both 1) puts its first I bit and first Q bit on ser_i and ser_q in the cycle that starts at that edge.
- R3: With cfg_short=0 and cfg_lsb_first=0 latched, the lanes carry bits 15, 14, ... 0 of in_i and in_q in 16 consecutive cycles.
- R4: With cfg_lsb_first=1 latched, the lanes carry bit 0 first and move upward to the top bit of the selected width.
- R5: With cfg_short=1 latched, each sample lasts 12 cycles, only bits 11..0 are sent, and bits 15..12 of the input words have no effect on the lanes.
- R6: strobe is 1 for exactly the first bit cycle of each sample and is 0 in all other cycles.
- R7: in_ready is 1 when no sample is in progress or when the current cycle carries the last bit of a sample, and is 0 otherwise. A word offered at that point starts with no gap cycle.
- R8: In a cycle with no sample bit, ser_i, ser_q and strobe are 0.
- R9: cfg_short and cfg_lsb_first are sampled only when a word is accepted. Changes to them during a sample do not alter that sample's length or bit order.
- R10: bit_en is 1 in every cycle that carries a sample bit and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, one bit period per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_short | input | 1 | 1 selects a 12-bit sample, 0 selects 16 bits |
| cfg_lsb_first | input | 1 | 1 sends bit 0 first, 0 sends the top bit first |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Block takes a word at this edge if in_valid is 1 |
| in_i | input | 16 | Parallel I word |
| in_q | input | 16 | Parallel Q word |
| bit_en | output | 1 | Current cycle carries a sample bit |
| strobe | output | 1 | First bit of a sample |
| ser_i | output | 1 | Serial I lane |
| ser_q | output | 1 | Serial Q lane |

## Verification
The assertions assume that in_valid is synchronous to clk and that an offered word and its settings are driven between edges rather than at them. They treat the settings as free to change in any cycle. The stimulus drives every input one time unit after the rising edge and keeps an offered word unchanged until the monitor observes the handshake. The settings are redrawn every cycle in the random phase, including mid-sample, so the latching rule is exercised without breaking those assumptions.

// File: rtl/iq_tx_pkg.sv
// Shared constants and types for the two-lane serial I/Q transmitter.
// Assumes the short width never exceeds the full width.
package iq_tx_pkg;
    localparam int unsigned FULL_W  = 16;
    localparam int unsigned SHORT_W = 12;

    // Settings captured at a sample boundary.
    typedef struct packed {
        logic short_w;
        logic lsb_first;
    } iq_cfg_t;
endpackage

// File: rtl/iq_tx_lane.sv
// One serial lane: holds a word and presents one bit per cycle.
// For top-bit-first order a short word is pre-aligned to the top of the
// register, so the output tap is always bit DW-1 (msb order) or bit 0
// (lsb order). Assumes load and shift are never high together in a way
// that matters: load wins.
module iq_tx_lane #(
    parameter int unsigned DW = 16,
    parameter int unsigned SW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          shift,
    input  logic          load_short,
    input  logic          load_lsb,
    input  logic          cur_lsb,
    input  logic [DW-1:0] din,
    output logic          dout
);
    localparam int unsigned PAD = DW - SW;

    logic [DW-1:0] sh_q;
    logic [DW-1:0] load_val;

    // Align the incoming word so the first bit sits at the output tap.
    always_comb begin
        if (load_lsb || !load_short) load_val = din;
        else                         load_val = din << PAD;
    end

    // Capture a new word or step the current one by one bit.
    always_ff @(posedge clk) begin
        if (!rst_n)     sh_q <= '0;
        else if (load)  sh_q <= load_val;
        else if (shift) sh_q <= cur_lsb ? (sh_q >> 1) : (sh_q << 1);
    end

    assign dout = cur_lsb ? sh_q[0] : sh_q[DW-1];
endmodule

// File: rtl/iq_tx_seq.sv
// Sample sequencer: counts bits, raises ready in the last bit, marks the
// first bit and latches the width/order settings when a word is taken.
// Assumes in_valid is synchronous to clk.
module iq_tx_seq #(
    parameter int unsigned DW = 16,
    parameter int unsigned SW = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_short,
    input  logic cfg_lsb_first,
    input  logic in_valid,
    output logic in_ready,
    output logic load,
    output logic shift,
    output logic active,
    output logic strobe,
    output logic cur_lsb
);
    import iq_tx_pkg::*;

    localparam int unsigned CW = $clog2(DW);

    logic          active_q;
    logic          first_q;
    logic [CW-1:0] cnt_q;
    iq_cfg_t       cfg_q;
    logic          last;

    // Decode the handshake and the stepping condition.
    always_comb begin
        last     = active_q && (cnt_q == '0);
        in_ready = !active_q || last;
        load     = in_valid && in_ready;
        shift    = active_q && !last;
    end

    // Track sample progress and capture settings at the boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            first_q  <= 1'b0;
            cnt_q    <= '0;
            cfg_q    <= '0;
        end else if (load) begin
            active_q        <= 1'b1;
            first_q         <= 1'b1;
            cnt_q           <= cfg_short ? CW'(SW - 1) : CW'(DW - 1);
            cfg_q.short_w   <= cfg_short;
            cfg_q.lsb_first <= cfg_lsb_first;
        end else if (active_q) begin
            first_q <= 1'b0;
            if (last) active_q <= 1'b0;
            else      cnt_q    <= cnt_q - 1'b1;
        end
    end

    assign active  = active_q;
    assign strobe  = active_q && first_q;
    assign cur_lsb = cfg_q.lsb_first;
endmodule

// File: rtl/iq_serial_tx.sv
// Top level: one sequencer driving two identical lanes (I and Q) so both
// lanes step together. Lane outputs are forced low outside a sample.
// Assumes a single clock where one cycle is one bit period.
module iq_serial_tx #(
    parameter int unsigned DW = iq_tx_pkg::FULL_W,
    parameter int unsigned SW = iq_tx_pkg::SHORT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_short,
    input  logic          cfg_lsb_first,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [DW-1:0] in_i,
    input  logic [DW-1:0] in_q,
    output logic          bit_en,
    output logic          strobe,
    output logic          ser_i,
    output logic          ser_q
);
    localparam int unsigned NLANE = 2;

    logic             load;
    logic             shift;
    logic             active;
    logic             cur_lsb;
    logic [DW-1:0]    lane_din [NLANE];
    logic [NLANE-1:0] lane_bit;

    assign lane_din[0] = in_i;
    assign lane_din[1] = in_q;

    iq_tx_seq #(.DW(DW), .SW(SW)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_short     (cfg_short),
        .cfg_lsb_first (cfg_lsb_first),
        .in_valid      (in_valid),
        .in_ready      (in_ready),
        .load          (load),
        .shift         (shift),
        .active        (active),
        .strobe        (strobe),
        .cur_lsb       (cur_lsb)
    );

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        iq_tx_lane #(.DW(DW), .SW(SW)) u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .load       (load),
            .shift      (shift),
            .load_short (cfg_short),
            .load_lsb   (cfg_lsb_first),
            .cur_lsb    (cur_lsb),
            .din        (lane_din[g]),
            .dout       (lane_bit[g])
        );
    end

    assign bit_en = active;
    assign ser_i  = active && lane_bit[0];
    assign ser_q  = active && lane_bit[1];
endmodule

// File: rtl/iq_serial_tx_chk.sv
// Protocol checker for iq_serial_tx, attached by bind. Observes ports only.
module iq_serial_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_ready,
    input logic bit_en,
    input logic strobe,
    input logic ser_i,
    input logic ser_q
);
    // R2
    load_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (strobe && bit_en));

    // R6
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe);

    // R6
    strobe_in_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> bit_en);

    // R7
    ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |-> in_ready);

    // R7
    ready_not_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> !in_ready);

    // R8
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |-> (!ser_i && !ser_q && !strobe));

    // R10
    sample_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && in_ready && !in_valid) |=> !bit_en);
endmodule

bind iq_serial_tx iq_serial_tx_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .bit_en   (bit_en),
    .strobe   (strobe),
    .ser_i    (ser_i),
    .ser_q    (ser_q)
);

// File: tb/iq_serial_tx_test.sv
module iq_serial_tx_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_short = 1'b0;
    logic        cfg_lsb_first = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_i = '0;
    logic [15:0] in_q = '0;
    logic        bit_en, strobe, ser_i, ser_q;

    always #4 clk = ~clk;

    iq_serial_tx uut (
        .clk(clk), .rst_n(rst_n), .cfg_short(cfg_short),
        .cfg_lsb_first(cfg_lsb_first), .in_valid(in_valid),
        .in_ready(in_ready), .in_i(in_i), .in_q(in_q),
        .bit_en(bit_en), .strobe(strobe), .ser_i(ser_i), .ser_q(ser_q)
    );

    int n_chk = 0;
    int n_fail = 0;

    // Reference model state for the current cycle.
    bit        mon_en = 1'b0;
    bit        hs_pending = 1'b0;
    bit        m_active = 1'b0;
    int        m_idx = 0;
    int        m_w = 16;
    bit        m_lsb = 1'b0;
    bit        m_short = 1'b0;
    bit [15:0] m_i = '0;
    bit [15:0] m_q = '0;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic bit exp_bit(input bit [15:0] w, input int idx,
                                   input int width, input bit lsb);
        return lsb ? w[idx] : w[width - 1 - idx];
    endfunction

    // Monitor: compare outputs to the model, then advance the model.
    always @(negedge clk) begin
        if (mon_en) begin
            bit    e_i, e_q, e_stb, e_rdy;
            string dtag;
            e_i   = m_active ? exp_bit(m_i, m_idx, m_w, m_lsb) : 1'b0;
            e_q   = m_active ? exp_bit(m_q, m_idx, m_w, m_lsb) : 1'b0;
            e_stb = m_active && (m_idx == 0);
            e_rdy = !m_active || (m_idx == m_w - 1);
            if (!m_active)                                   dtag = "R8";
            else if (m_idx == 0)                             dtag = "R2";
            else if (cfg_short != m_short || cfg_lsb_first != m_lsb) dtag = "R9";
            else if (m_short)                                dtag = "R5";
            else if (m_lsb)                                  dtag = "R4";
            else                                             dtag = "R3";
            check(ser_i == e_i, dtag, "ser_i", int'(ser_i), int'(e_i));
            check(ser_q == e_q, dtag, "ser_q", int'(ser_q), int'(e_q));
            check(strobe == e_stb, "R6", "strobe", int'(strobe), int'(e_stb));
            check(in_ready == e_rdy, "R7", "in_ready", int'(in_ready), int'(e_rdy));
            check(bit_en == m_active, "R10", "bit_en", int'(bit_en), int'(m_active));
            hs_pending = in_valid && e_rdy;
            if (in_valid && e_rdy) begin
                m_active = 1'b1;
                m_idx    = 0;
                m_short  = cfg_short;
                m_w      = cfg_short ? 12 : 16;
                m_lsb    = cfg_lsb_first;
                m_i      = in_i;
                m_q      = in_q;
            end else if (m_active) begin
                if (m_idx == m_w - 1) m_active = 1'b0;
                else                  m_idx++;
            end
        end
    end

    // Drive stimulus; an offered word stays until its handshake is seen.
    task automatic run(input int cycles, input int vprob, input bit rnd_cfg,
                       input bit fshort, input bit flsb);
        for (int c = 0; c < cycles; c++) begin
            @(posedge clk);
            #1;
            if (hs_pending || !in_valid) begin
                hs_pending = 1'b0;
                if (($urandom % 100) < vprob) begin
                    in_valid = 1'b1;
                    in_i     = 16'($urandom);
                    in_q     = 16'($urandom);
                end else begin
                    in_valid = 1'b0;
                end
            end
            if (rnd_cfg) begin
                cfg_short     = 1'($urandom);
                cfg_lsb_first = 1'($urandom);
            end else begin
                cfg_short     = fshort;
                cfg_lsb_first = flsb;
            end
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2024));
        in_valid = 1'b1;
        in_i = 16'hFFFF;
        in_q = 16'hFFFF;
        repeat (3) @(negedge clk);
        // R1: reset state even with a word offered
        check(in_ready == 1'b1, "R1", "in_ready", int'(in_ready), 1);
        check(bit_en == 1'b0, "R1", "bit_en", int'(bit_en), 0);
        check(strobe == 1'b0, "R1", "strobe", int'(strobe), 0);
        check(ser_i == 1'b0 && ser_q == 1'b0, "R1", "lanes",
              int'({ser_i, ser_q}), 0);
        @(posedge clk);
        #1;
        rst_n    = 1'b1;
        in_valid = 1'b0;
        mon_en   = 1'b1;
        // directed: pattern words, back to back (R3, R7)
        @(posedge clk);
        #1;
        in_valid = 1'b1;
        in_i = 16'h8001;
        in_q = 16'h7FFE;
        run(200, 100, 1'b0, 1'b0, 1'b0);
        // 12-bit lsb-first with upper bits randomised (R4, R5)
        run(200, 100, 1'b0, 1'b1, 1'b1);
        // 12-bit msb-first, gaps between words (R5, R8)
        run(150, 50, 1'b0, 1'b1, 1'b0);
        // 16-bit lsb-first (R4)
        run(150, 80, 1'b0, 1'b0, 1'b1);
        // settings changing every cycle (R9)
        run(2500, 70, 1'b1, 1'b0, 1'b0);
        // drain to idle (R8)
        run(40, 0, 1'b0, 1'b0, 1'b0);
        finish_run();
    end
endmodule